// File: doc/BRIEF.md
# SONET Line Defect Monitor

This block sits behind the receive framer of a SONET/SDH line interface and turns per-frame observations into filtered defect flags. It samples the received K2 overhead byte, the out-of-frame indication and the frame strobe once per frame. It also watches a loss-of-signal input. From these it keeps four registered outputs: line alarm indication (LAIS), line remote defect indication (LRDI), loss of frame (LOF), and a request to send RDI back towards the far end.

The K2 flags need a pattern to hold for a configurable number of back-to-back frames before they change state in either direction. LOF needs a long run of out-of-frame frames before it is declared. It clears after a run of clean frames, either a short run or a long run as configured. The LOS input can be declared active high or active low, and it can be kept out of the RDI request.

Top module: `line_defect_mon`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `lais_o`, `lrdi_o`, `lof_o` and `rdi_req_o` are 0, and all persistence counts restart from zero.
- R2: `lais_o` rises after `k2_byte[3:1]` equals 3'b111 on N back-to-back strobed frames while it is low. N is `cfg_persist`.
- R3: `lais_o` falls after N back-to-back strobed frames whose `k2_byte[3:1]` is not 3'b111. Any frame that matches the current flag state restarts the run.
- R4: `lrdi_o` follows the same set and clear rules as LAIS, using the pattern `k2_byte[3:1]` == 3'b110.
- R5: A `cfg_persist` value of 0 acts exactly as a value of 1.
- R6: `lof_o` rises on the 24th back-to-back strobed frame with `oof_in` high. A strobed frame with `oof_in` low restarts that count.
- R7: While `lof_o` is high, it falls after 8 back-to-back strobed frames with `oof_in` low when `cfg_lof_fast`=1, or after 24 such frames when `cfg_lof_fast`=0. A strobed frame with `oof_in` high restarts the clear count.
- R8: LOS is active when `los_in` is 0 if `cfg_los_act_low`=1, and when `los_in` is 1 if `cfg_los_act_low`=0.
- R9: With `cfg_los_mask`=1, an active LOS has no effect on `rdi_req_o`.
- R10: `rdi_req_o` equals, one clock later, the OR of `lais_o`, `lof_o` and the unmasked active LOS.
- R11: The values of `k2_byte` and `oof_in` on cycles where `frame_stb` is low have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| k2_byte | input | 8 | Received K2 byte, valid with `frame_stb` |
| oof_in | input | 1 | Out-of-frame indication, sampled with `frame_stb` |
| los_in | input | 1 | Loss-of-signal input, polarity set by `cfg_los_act_low` |
| cfg_persist | input | 4 | Consecutive-frame count for K2 set/clear (0 acts as 1) |
| cfg_los_act_low | input | 1 | 1: LOS active low, 0: LOS active high |
| cfg_los_mask | input | 1 | 1: LOS excluded from the RDI request |
| cfg_lof_fast | input | 1 | 1: LOF clears after 8 clean frames, 0: after 24 |
| lais_o | output | 1 | Filtered line AIS |
| lrdi_o | output | 1 | Filtered line RDI |
| lof_o | output | 1 | Loss of frame |
| rdi_req_o | output | 1 | Request to send RDI upstream |

## Verification
The bench builds the block with its default parameters: an 8-bit K2 byte, a 4-bit persistence count, 24 frames to declare LOF, and clear runs of 8 and 24. This keeps the full 24-frame declare and clear windows cheap to reach, along with both clear speeds and the interrupted-run restarts. The random phase keeps `cfg_persist` between 0 and 6 and makes the K2 and OOF inputs sticky. As a result, both K2 flags toggle many times and LOF enters and leaves often, alongside the directed edge cases at exactly N-1 and N frames.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  // K2 bits 3..1 carry the line maintenance code
  localparam int          K2_CODE_LSB = 1;
  localparam int          K2_CODE_W   = 3;
  localparam logic [2:0]  CODE_AIS    = 3'b111;
  localparam logic [2:0]  CODE_RDI    = 3'b110;
  localparam int          NUM_K2_DEF  = 2;

  typedef enum int {DEF_AIS = 0, DEF_RDI = 1} k2_def_e;

  function automatic logic [2:0] code_for(int idx);
    return (idx == DEF_AIS) ? CODE_AIS : CODE_RDI;
  endfunction
endpackage

// File: rtl/ldm_k2_filter.sv
module ldm_k2_filter #(
  parameter int         CNTW    = 4,
  parameter logic [2:0] PATTERN = 3'b111
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic [2:0]      code,
  input  logic [CNTW-1:0] persist,
  output logic            flag_o
);
  localparam int RUNW = CNTW + 1;

  logic [RUNW-1:0] run_q;
  logic [RUNW-1:0] need;
  logic            hit;

  assign need = (persist == '0) ? RUNW'(1) : {1'b0, persist};
  assign hit  = (code == PATTERN);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      run_q  <= '0;
    end else if (stb) begin
      if (hit != flag_o) begin
        if (run_q + RUNW'(1) >= need) begin
          flag_o <= hit;
          run_q  <= '0;
        end else begin
          run_q <= run_q + RUNW'(1);
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ldm_lof_tracker.sv
module ldm_lof_tracker #(
  parameter int SET_FRAMES = 24,
  parameter int CLR_SLOW   = 24,
  parameter int CLR_FAST   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic oof,
  input  logic fast,
  output logic lof_o
);
  localparam int CLR_MAX = (CLR_SLOW > CLR_FAST) ? CLR_SLOW : CLR_FAST;
  localparam int SW      = $clog2(SET_FRAMES + 1);
  localparam int CW      = $clog2(CLR_MAX + 1);

  logic [SW-1:0] oof_run_q;
  logic [CW-1:0] clean_q;
  logic [CW-1:0] clr_need;

  assign clr_need = fast ? CW'(CLR_FAST) : CW'(CLR_SLOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      oof_run_q <= '0;
      clean_q   <= '0;
      lof_o     <= 1'b0;
    end else if (stb) begin
      if (oof) begin
        clean_q <= '0;
        if (oof_run_q < SW'(SET_FRAMES))
          oof_run_q <= oof_run_q + SW'(1);
        if (int'(oof_run_q) + 1 >= SET_FRAMES)
          lof_o <= 1'b1;
      end else begin
        oof_run_q <= '0;
        if (lof_o) begin
          if (int'(clean_q) + 1 >= int'(clr_need)) begin
            lof_o   <= 1'b0;
            clean_q <= '0;
          end else begin
            clean_q <= clean_q + CW'(1);
          end
        end else begin
          clean_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ldm_rdi_gen.sv
module ldm_rdi_gen (
  input  logic clk,
  input  logic rst,
  input  logic los_raw,
  input  logic act_low,
  input  logic mask,
  input  logic lais,
  input  logic lof,
  output logic rdi_o
);
  logic los_active;

  assign los_active = los_raw ^ act_low;

  always_ff @(posedge clk) begin
    if (rst) rdi_o <= 1'b0;
    else     rdi_o <= lais | lof | (los_active & ~mask);
  end
endmodule

// File: rtl/line_defect_mon.sv
module line_defect_mon #(
  parameter int K2W        = 8,
  parameter int CNTW       = 4,
  parameter int LOF_SET    = 24,
  parameter int LOF_CLR_SL = 24,
  parameter int LOF_CLR_FS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_stb,
  input  logic [K2W-1:0]  k2_byte,
  input  logic            oof_in,
  input  logic            los_in,
  input  logic [CNTW-1:0] cfg_persist,
  input  logic            cfg_los_act_low,
  input  logic            cfg_los_mask,
  input  logic            cfg_lof_fast,
  output logic            lais_o,
  output logic            lrdi_o,
  output logic            lof_o,
  output logic            rdi_req_o
);
  import ldm_pkg::*;

  logic [K2_CODE_W-1:0]  k2_code;
  logic [NUM_K2_DEF-1:0] k2_flags;
  logic                  unused_k2;

  assign k2_code   = k2_byte[K2_CODE_LSB +: K2_CODE_W];
  assign unused_k2 = ^k2_byte;

  for (genvar g = 0; g < NUM_K2_DEF; g++) begin : g_k2
    ldm_k2_filter #(
      .CNTW    (CNTW),
      .PATTERN (code_for(g))
    ) u_filt (
      .clk     (clk),
      .rst     (rst),
      .stb     (frame_stb),
      .code    (k2_code),
      .persist (cfg_persist),
      .flag_o  (k2_flags[g])
    );
  end

  assign lais_o = k2_flags[DEF_AIS];
  assign lrdi_o = k2_flags[DEF_RDI];

  ldm_lof_tracker #(
    .SET_FRAMES (LOF_SET),
    .CLR_SLOW   (LOF_CLR_SL),
    .CLR_FAST   (LOF_CLR_FS)
  ) u_lof (
    .clk   (clk),
    .rst   (rst),
    .stb   (frame_stb),
    .oof   (oof_in),
    .fast  (cfg_lof_fast),
    .lof_o (lof_o)
  );

  ldm_rdi_gen u_rdi (
    .clk     (clk),
    .rst     (rst),
    .los_raw (los_in),
    .act_low (cfg_los_act_low),
    .mask    (cfg_los_mask),
    .lais    (lais_o),
    .lof     (lof_o),
    .rdi_o   (rdi_req_o)
  );
endmodule

// File: rtl/ldm_checker.sv
module ldm_checker (
  input logic       clk,
  input logic       rst,
  input logic       frame_stb,
  input logic [7:0] k2_byte,
  input logic       oof_in,
  input logic       los_in,
  input logic       cfg_los_act_low,
  input logic       cfg_los_mask,
  input logic       lais_o,
  input logic       lrdi_o,
  input logic       lof_o,
  input logic       rdi_req_o
);
  // R1: flags cleared on the clock after reset
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!lais_o && !lrdi_o && !lof_o && !rdi_req_o));

  // R2: LAIS can only rise after a strobed frame carrying the AIS code
  p_lais_rise_code_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lais_o) |-> ($past(frame_stb) && $past(k2_byte[3:1]) == 3'b111));

  // R3: LAIS can only fall after a strobed frame without the AIS code
  p_lais_fall_code_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lais_o) |-> ($past(frame_stb) && $past(k2_byte[3:1]) != 3'b111));

  // R4: LRDI can only rise after a strobed frame carrying the RDI code
  p_lrdi_rise_code_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(lrdi_o) |-> ($past(frame_stb) && $past(k2_byte[3:1]) == 3'b110));

  // R6: LOF is declared only on a strobed frame with OOF high
  p_lof_rise_oof_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(lof_o) |-> ($past(frame_stb) && $past(oof_in)));

  // R7: LOF clears only on a strobed clean frame
  p_lof_fall_clean_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(lof_o) |-> ($past(frame_stb) && !$past(oof_in)));

  // R10: any cause present forces the request on the following clock
  p_rdi_causes_r10: assert property (@(posedge clk) disable iff (rst)
    (lais_o || lof_o || ((los_in ^ cfg_los_act_low) && !cfg_los_mask)) |=> rdi_req_o);

  // R9: request without LAIS/LOF needs an unmasked active LOS
  p_rdi_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (!lais_o && !lof_o && cfg_los_mask) |=> !rdi_req_o);

  // R11: flags hold on cycles without a strobe
  p_hold_no_stb_r11: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> ($stable(lais_o) && $stable(lrdi_o) && $stable(lof_o)));
endmodule

bind line_defect_mon ldm_checker u_ldm_chk (
  .clk             (clk),
  .rst             (rst),
  .frame_stb       (frame_stb),
  .k2_byte         (k2_byte),
  .oof_in          (oof_in),
  .los_in          (los_in),
  .cfg_los_act_low (cfg_los_act_low),
  .cfg_los_mask    (cfg_los_mask),
  .lais_o          (lais_o),
  .lrdi_o          (lrdi_o),
  .lof_o           (lof_o),
  .rdi_req_o       (rdi_req_o)
);

// File: tb/sim_line_defect_mon.sv
`timescale 1ns/1ps
module sim_line_defect_mon;
  logic       clk = 1'b0;
  logic       rst;
  logic       frame_stb;
  logic [7:0] k2_byte;
  logic       oof_in;
  logic       los_in;
  logic [3:0] cfg_persist;
  logic       cfg_los_act_low;
  logic       cfg_los_mask;
  logic       cfg_lof_fast;
  logic       lais_o, lrdi_o, lof_o, rdi_req_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  bit m_lais, m_lrdi, m_lof;
  int run_a, run_r, oof_run, clean_run;

  always #2.5 clk = ~clk;

  line_defect_mon u0 (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .k2_byte(k2_byte),
    .oof_in(oof_in), .los_in(los_in), .cfg_persist(cfg_persist),
    .cfg_los_act_low(cfg_los_act_low), .cfg_los_mask(cfg_los_mask),
    .cfg_lof_fast(cfg_lof_fast), .lais_o(lais_o), .lrdi_o(lrdi_o),
    .lof_o(lof_o), .rdi_req_o(rdi_req_o));

  function automatic int need_frames();
    return (cfg_persist == 4'd0) ? 1 : int'(cfg_persist);   // R5
  endfunction

  function automatic void step_flag(inout bit flag, inout int run, input bit hit);
    if (hit != flag) begin
      run++;
      if (run >= need_frames()) begin flag = hit; run = 0; end
    end else run = 0;
  endfunction

  function automatic void model_frame(input logic [7:0] k2, input bit oof);
    step_flag(m_lais, run_a, k2[3:1] == 3'b111);
    step_flag(m_lrdi, run_r, k2[3:1] == 3'b110);
    if (oof) begin
      clean_run = 0;
      oof_run++;
      if (oof_run >= 24) m_lof = 1;
    end else begin
      oof_run = 0;
      if (m_lof) begin
        clean_run++;
        if (clean_run >= (cfg_lof_fast ? 8 : 24)) begin m_lof = 0; clean_run = 0; end
      end else clean_run = 0;
    end
  endfunction

  function automatic bit exp_rdi();
    bit los_act = cfg_los_act_low ? !los_in : los_in;
    return m_lais | m_lof | (los_act & !cfg_los_mask);
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "lais_o", lais_o, m_lais);
    chk(req, "lrdi_o", lrdi_o, m_lrdi);
    chk(req, "lof_o", lof_o, m_lof);
    chk(req, "rdi_req_o", rdi_req_o, exp_rdi());
  endtask

  // one frame: strobe cycle, then junk inputs between strobes (R11)
  task automatic frame(input logic [7:0] k2, input bit oof);
    @(negedge clk);
    frame_stb = 1'b1; k2_byte = k2; oof_in = oof;
    @(negedge clk);
    frame_stb = 1'b0; k2_byte = 8'($urandom); oof_in = 1'($urandom);
    model_frame(k2, oof);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic frames(input int n, input logic [7:0] k2, input bit oof);
    for (int i = 0; i < n; i++) frame(k2, oof);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] k2_cur;
    bit         oof_cur;
    void'($urandom(32'd20240611));
    rst = 1; frame_stb = 0; k2_byte = 0; oof_in = 0; los_in = 1;
    cfg_persist = 4'd5; cfg_los_act_low = 1; cfg_los_mask = 0; cfg_lof_fast = 0;
    m_lais = 0; m_lrdi = 0; m_lof = 0; run_a = 0; run_r = 0; oof_run = 0; clean_run = 0;
    repeat (5) @(negedge clk);
    chk("R1", "lais_o in reset", lais_o, 1'b0);
    chk("R1", "lof_o in reset", lof_o, 1'b0);
    rst = 0;
    @(negedge clk);
    chk_all("R1");

    // R2 / R3 with a count of 3
    cfg_persist = 4'd3;
    frames(2, 8'h0E, 0);
    chk("R2", "lais_o after 2 of 3", lais_o, 1'b0);
    frame(8'h0E, 0);
    chk("R2", "lais_o after 3 of 3", lais_o, 1'b1);
    chk("R10", "rdi_req_o with LAIS", rdi_req_o, 1'b1);
    frames(2, 8'h00, 0);
    frame(8'h0E, 0);              // run interrupted
    frames(2, 8'h00, 0);
    chk("R3", "lais_o after interrupted clear run", lais_o, 1'b1);
    frame(8'h00, 0);
    chk("R3", "lais_o after 3 clean", lais_o, 1'b0);
    chk_all("R3");

    // R11: K2 code held between strobes does nothing
    @(negedge clk);
    cfg_persist = 4'd1; k2_byte = 8'h0E; oof_in = 1;
    repeat (12) @(negedge clk);
    chk("R11", "lais_o with unstrobed code", lais_o, 1'b0);
    chk("R11", "lof_o with unstrobed oof", lof_o, 1'b0);

    // R4 / R5: count 0 behaves as 1
    cfg_persist = 4'd0;
    frame(8'hFC, 0);
    chk("R5", "lrdi_o after 1 frame with count 0", lrdi_o, 1'b1);
    chk("R4", "lais_o stays low on RDI code", lais_o, 1'b0);
    frame(8'h00, 0);
    chk("R4", "lrdi_o clears after 1 frame", lrdi_o, 1'b0);

    // R6: declare LOF
    frames(23, 8'h00, 1);
    chk("R6", "lof_o after 23 oof", lof_o, 1'b0);
    frame(8'h00, 0);
    frames(23, 8'h00, 1);
    chk("R6", "lof_o after restart + 23", lof_o, 1'b0);
    frame(8'h00, 1);
    chk("R6", "lof_o after 24 oof", lof_o, 1'b1);
    chk("R10", "rdi_req_o with LOF", rdi_req_o, 1'b1);

    // R7: slow clear with interruption
    frames(23, 8'h00, 0);
    frame(8'h00, 1);
    frames(23, 8'h00, 0);
    chk("R7", "lof_o after restart + 23 clean", lof_o, 1'b1);
    frame(8'h00, 0);
    chk("R7", "lof_o after 24 clean (slow)", lof_o, 1'b0);

    // R7: fast clear
    cfg_lof_fast = 1;
    frames(24, 8'h00, 1);
    chk("R7", "lof_o redeclared", lof_o, 1'b1);
    frames(7, 8'h00, 0);
    chk("R7", "lof_o after 7 clean (fast)", lof_o, 1'b1);
    frame(8'h00, 0);
    chk("R7", "lof_o after 8 clean (fast)", lof_o, 1'b0);

    // R8 / R9: LOS polarity and mask
    @(negedge clk); cfg_los_act_low = 1; los_in = 0;
    repeat (3) @(negedge clk);
    chk("R8", "rdi_req_o LOS low active", rdi_req_o, 1'b1);
    los_in = 1;
    repeat (3) @(negedge clk);
    chk("R8", "rdi_req_o LOS high idle", rdi_req_o, 1'b0);
    cfg_los_act_low = 0;
    repeat (3) @(negedge clk);
    chk("R8", "rdi_req_o LOS high active", rdi_req_o, 1'b1);
    cfg_los_mask = 1;
    repeat (3) @(negedge clk);
    chk("R9", "rdi_req_o LOS masked", rdi_req_o, 1'b0);
    chk("R9", "lof_o unaffected by LOS", lof_o, 1'b0);

    // random phase, checked every frame against the reference
    k2_cur = 8'h00; oof_cur = 0;
    for (int f = 0; f < 2500; f++) begin
      if (f % 150 == 0) begin
        @(negedge clk);
        cfg_persist     = 4'($urandom_range(0, 6));
        cfg_lof_fast    = 1'($urandom);
        cfg_los_act_low = 1'($urandom);
        cfg_los_mask    = 1'($urandom);
        los_in          = 1'($urandom);
      end
      if ($urandom_range(0, 99) < 15) begin
        case ($urandom_range(0, 2))
          0:       k2_cur = {4'($urandom), 3'b111, 1'($urandom)};
          1:       k2_cur = {4'($urandom), 3'b110, 1'($urandom)};
          default: k2_cur = 8'($urandom);
        endcase
      end
      if ($urandom_range(0, 99) < 4) oof_cur = !oof_cur;
      frame(k2_cur, oof_cur);
      chk_all("R2 R3 R4 R6 R7 R10 random");
    end

    finish_run();
  end
endmodule